// File: doc/BRIEF.md
# Load Data Byte Formatter

This block sits in the writeback stage of a pipeline and turns a raw 64-bit doubleword read from memory into the value a load delivers. It is given the byte offset at which the access starts, the access length, and flags for byte reversal, sign extension, record mode and "second beat of a two-beat access". A byte crossbar moves the wanted bytes down to the low end of the word, reversing their order if asked, in the same step. Per-lane logic then clears or sign-fills the lanes above the access length. For an access that crosses into the next doubleword, the crossbar output of the first doubleword is kept in a register and combined lane by lane with the crossbar output of the second.

When record mode is requested, the final 64-bit value is compared with zero as a signed number and a 4-bit condition field is produced. The result and the condition field are registered and hold their values until the next completed access.

The caller presents each doubleword as a beat with `in_valid` high. An access whose start offset plus length exceeds the lane count is a split access: its first beat has `in_tail` low and its second beat has `in_tail` high, with the same offset, size and flags on both beats. Any number of idle cycles may come between the two beats.

Top module: `load_byte_formatter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_data` and `out_cr` are 0 after that edge.
- R2: For an access that fits in one doubleword (offset + length <= 8), with size code 0/1/2/3 meaning 1/2/4/8 bytes and reversal off, result byte k equals input byte offset+k for k below the length, and `out_valid` is high for exactly the one cycle after the beat.
- R3: With `in_rev` = 1, result byte k equals input byte offset+length-1-k for k below the length.
- R4: With `in_sext` = 1, every result byte at or above the length is 0xFF when bit 7 of result byte length-1 is set, and 0x00 otherwise.
- R5: With `in_sext` = 0, every result byte at or above the length is 0x00.
- R6: For a split access (offset + length > 8), the first beat (`in_tail` = 0) produces no output: `out_valid` stays low and `out_data` is unchanged. After the second beat (`in_tail` = 1), result byte k is memory byte offset+k, where memory bytes 0..7 are the first beat and 8..15 are the second.
- R7: A split access with `in_rev` = 1 gives result byte k equal to memory byte offset+length-1-k, drawn from the first or second beat as that index falls.
- R8: With `in_rc` = 1, `out_cr` bit 3 is set for a negative result, bit 2 for a positive non-zero result, bit 1 for a zero result, and bit 0 is always 0; exactly one of bits 3..1 is set.
- R9: With `in_rc` = 0, `out_cr` is 0000.
- R10: The held first doubleword survives any number of idle cycles between the two beats of a split access.
- R11: In cycles without a completed access, `out_valid` is low and `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A doubleword beat is present |
| in_tail | input | 1 | This beat is the second of a split access |
| in_data | input | 64 | Doubleword from memory, byte 0 in bits 7:0 |
| in_offset | input | 3 | Byte offset of the access start within the first doubleword |
| in_size | input | 2 | Length code: 0=1, 1=2, 2=4, 3=8 bytes |
| in_rev | input | 1 | Reverse byte order of the accessed bytes |
| in_sext | input | 1 | Sign-extend the result above the access length |
| in_rc | input | 1 | Produce a condition field from the result |
| out_valid | output | 1 | Result registered from the final beat of an access |
| out_data | output | 64 | Formatted result |
| out_cr | output | 4 | Condition field: LT, GT, EQ, 0 from bit 3 down |

## Verification
The bench builds the block with its default of eight byte lanes, which makes the whole space of start offsets, the four lengths, both byte orders and both extension modes small enough to sweep completely: 128 accesses, of which the ones whose offset plus length passes eight go through the two-beat path. That sweep reaches every lane-selection pattern of the crossbar and every boundary between held and current lanes. Directed cases then stretch the gap between beats and drive the condition field through its negative, positive and zero outcomes.

// File: rtl/ldfmt_pkg.sv
// Package: shared constants and lane-position arithmetic for the load
// data byte formatter. Assumes the lane count is a power of two.
package ldfmt_pkg;

    // Bit positions inside the 4-bit condition field.
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;

    // Number of bytes an access covers for a given size code.
    function automatic int access_len(int size_code);
        return 1 << size_code;
    endfunction

    // Position, counted across two concatenated doublewords, of the
    // memory byte that lands in result lane 'lane'.
    function automatic int src_pos(int ofs, int size_code, logic rev, int lane);
        int len;
        len = access_len(size_code);
        if (rev)
            return ofs + len - 1 - lane;
        return ofs + lane;
    endfunction

    // Wrap a position into a lane index (handles negative positions).
    function automatic int lane_wrap(int pos, int lanes);
        return ((pos % lanes) + lanes) % lanes;
    endfunction

endpackage

// File: rtl/ldfmt_xbar.sv
// Module: ldfmt_xbar
// Byte crossbar. Each output lane is an N:1 multiplexer over all input
// lanes, with its select computed from offset, size and the reverse flag,
// so rotation and byte reversal are one step. Purely combinational.
// Assumes LANES is a power of two.
module ldfmt_xbar
    import ldfmt_pkg::*;
#(
    parameter  int LANES = 8,
    localparam int OFS_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFS_W + 1)
) (
    input  logic [LANES-1:0][7:0] din,
    input  logic [OFS_W-1:0]      offset,
    input  logic [SZ_W-1:0]       size,
    input  logic                  rev,
    output logic [LANES-1:0][7:0] dout
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFS_W-1:0] sel;

        // Select the input lane feeding output lane k.
        always_comb begin
            sel = OFS_W'(lane_wrap(src_pos(int'(offset), int'(size), rev, k), LANES));
        end

        // The N:1 byte multiplexer of lane k.
        always_comb begin
            dout[k] = din[sel];
        end
    end

endmodule

// File: rtl/ldfmt_lane.sv
// Module: ldfmt_lane
// Per-lane finishing logic. Splices lanes of the held first doubleword
// with the current crossbar output, locates the sign byte, then trims or
// sign-fills lanes above the access length. Combinational.
// Assumes both inputs were produced by the crossbar with the same
// offset, size and reverse settings.
module ldfmt_lane
    import ldfmt_pkg::*;
#(
    parameter  int LANES = 8,
    localparam int OFS_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFS_W + 1)
) (
    input  logic [LANES-1:0][7:0] cur,
    input  logic [LANES-1:0][7:0] held,
    input  logic                  use_held,
    input  logic [OFS_W-1:0]      offset,
    input  logic [SZ_W-1:0]       size,
    input  logic                  rev,
    input  logic                  sext,
    output logic [LANES-1:0][7:0] dout
);

    logic [LANES-1:0][7:0] spliced;
    logic [LANES-1:0]      from_held;
    logic                  sgn;
    logic [7:0]            fill;

    for (genvar k = 0; k < LANES; k++) begin : g_splice
        // Lane k comes from the held word when its source lies in the first doubleword.
        always_comb begin
            from_held[k] = use_held &&
                           (src_pos(int'(offset), int'(size), rev, k) < LANES);
            spliced[k]   = from_held[k] ? held[k] : cur[k];
        end
    end

    // Pick the top bit of the most significant valid lane.
    always_comb begin
        sgn = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            if (j == access_len(int'(size)) - 1)
                sgn = spliced[j][7];
        end
    end

    // Fill value for lanes above the access length.
    always_comb begin
        fill = {8{sext & sgn}};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_trim
        // Keep lanes inside the access, replace the rest with the fill.
        always_comb begin
            if (k < access_len(int'(size)))
                dout[k] = spliced[k];
            else
                dout[k] = fill;
        end
    end

endmodule

// File: rtl/ldfmt_cond.sv
// Module: ldfmt_cond
// Condition-field generator: signed compare of the result with zero.
// Produces LT/GT/EQ with bit 0 forced to 0, or all zeros when record
// mode is off. Combinational.
module ldfmt_cond
    import ldfmt_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] d,
    input  logic          rc,
    output logic [3:0]    cr
);

    logic is_zero;
    logic is_neg;

    // Zero and sign detection on the full result.
    always_comb begin
        is_zero = (d == '0);
        is_neg  = d[DW-1];
    end

    // Assemble the nibble when record mode is on.
    always_comb begin
        cr = 4'b0000;
        if (rc) begin
            cr[CR_LT] = is_neg;
            cr[CR_GT] = !is_neg && !is_zero;
            cr[CR_EQ] = is_zero;
            cr[CR_SO] = 1'b0;
        end
    end

endmodule

// File: rtl/load_byte_formatter.sv
// Module: load_byte_formatter
// Top of the load data formatter. Runs each beat through the byte
// crossbar, keeps the crossbar output of the first beat of a split
// access, finishes the lanes, derives the condition field and registers
// the result one cycle after the final beat.
// Assumes: offset, size and flags are identical on both beats of a split
// access; a tail beat is only sent after its first beat.
module load_byte_formatter
    import ldfmt_pkg::*;
#(
    parameter  int LANES = 8,
    localparam int DW    = LANES * 8,
    localparam int OFS_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFS_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_tail,
    input  logic [DW-1:0]    in_data,
    input  logic [OFS_W-1:0] in_offset,
    input  logic [SZ_W-1:0]  in_size,
    input  logic             in_rev,
    input  logic             in_sext,
    input  logic             in_rc,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic [3:0]       out_cr
);

    logic [LANES-1:0][7:0] xbar_out;
    logic [LANES-1:0][7:0] held_q;
    logic [LANES-1:0][7:0] fmt_lanes;
    logic [DW-1:0]         fmt_data;
    logic [3:0]            cond;
    logic                  is_split;
    logic                  head_beat;
    logic                  final_beat;
    logic                  pend_q;

    // Rotate and optionally reverse the incoming beat.
    ldfmt_xbar #(.LANES(LANES)) u_xbar (
        .din    (in_data),
        .offset (in_offset),
        .size   (in_size),
        .rev    (in_rev),
        .dout   (xbar_out)
    );

    // Classify the beat: split head, or final beat of an access.
    always_comb begin
        is_split   = (int'(in_offset) + access_len(int'(in_size))) > LANES;
        head_beat  = in_valid && !in_tail && is_split;
        final_beat = in_valid && (in_tail || !is_split);
    end

    // Hold the crossbar output of a split head; no reset, no zero leg.
    always_ff @(posedge clk) begin
        if (head_beat)
            held_q <= xbar_out;
    end

    // Track that a split head is waiting for its tail.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (head_beat)
            pend_q <= 1'b1;
        else if (in_valid && in_tail)
            pend_q <= 1'b0;
    end

    // Splice, trim and sign-extend the lanes.
    ldfmt_lane #(.LANES(LANES)) u_lane (
        .cur      (xbar_out),
        .held     (held_q),
        .use_held (in_tail),
        .offset   (in_offset),
        .size     (in_size),
        .rev      (in_rev),
        .sext     (in_sext),
        .dout     (fmt_lanes)
    );

    // Flatten the lane array into the result word.
    always_comb begin
        fmt_data = fmt_lanes;
    end

    // Condition field from the finished result.
    ldfmt_cond #(.DW(DW)) u_cond (
        .d  (fmt_data),
        .rc (in_rc),
        .cr (cond)
    );

    // Register the result one cycle after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_cr    <= 4'b0000;
        end else begin
            out_valid <= final_beat;
            if (final_beat) begin
                out_data <= fmt_data;
                out_cr   <= cond;
            end
        end
    end

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && out_cr == 4'b0000));

    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sext && in_size == '0) |-> (fmt_data[DW-1:8] == '0));

    // R6
    head_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_beat |=> (!out_valid && $stable(out_data)));

    // R8
    cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cr != 4'b0000) |-> ($countones(out_cr[3:1]) == 1 && !out_cr[CR_SO]));

    // R8
    cond_eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr[CR_EQ] |-> (out_data == '0));

    // R10
    tail_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_tail) |-> pend_q);

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

// File: tb/load_byte_formatter_test.sv
module load_byte_formatter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_tail, in_rev, in_sext, in_rc;
    logic [63:0] in_data;
    logic [2:0]  in_offset;
    logic [1:0]  in_size;
    logic        out_valid;
    logic [63:0] out_data;
    logic [3:0]  out_cr;

    int checks = 0;
    int errors = 0;
    logic [7:0]  mem [16];
    logic [63:0] last_out = '0;

    always #10 clk = ~clk;  // 50 MHz

    load_byte_formatter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tail(in_tail),
        .in_data(in_data), .in_offset(in_offset), .in_size(in_size),
        .in_rev(in_rev), .in_sext(in_sext), .in_rc(in_rc),
        .out_valid(out_valid), .out_data(out_data), .out_cr(out_cr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic fill_mem(input int seed);
        for (int i = 0; i < 16; i++)
            mem[i] = 8'(seed * 37 + i * 29 + 11 + ((seed + i) % 3) * 64);
    endtask

    // One access through the ports, checked against a byte-level model.
    task automatic access(input int o, input int s, input bit rev, input bit sext,
                          input bit rc, input int gap, input string tag);
        int          len;
        bit          split;
        logic [63:0] d1, d2, exp;
        logic [7:0]  sb, fb;
        logic [3:0]  ecr;
        len   = 1 << s;
        split = (o + len) > 8;
        for (int i = 0; i < 8; i++) begin
            d1[i*8 +: 8] = mem[i];
            d2[i*8 +: 8] = mem[i+8];
        end
        sb = rev ? mem[o] : mem[o+len-1];
        fb = (sext && sb[7]) ? 8'hFF : 8'h00;
        for (int k = 0; k < 8; k++)
            exp[k*8 +: 8] = (k < len) ? (rev ? mem[o+len-1-k] : mem[o+k]) : fb;
        ecr = !rc ? 4'b0000 : (exp == 0) ? 4'b0010 : exp[63] ? 4'b1000 : 4'b0100;
        in_offset = 3'(o); in_size = 2'(s); in_rev = rev; in_sext = sext; in_rc = rc;
        if (split) begin
            @(negedge clk);
            in_valid = 1'b1; in_tail = 1'b0; in_data = d1;
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid == 1'b0, "R6 head beat valid", 64'(out_valid), 64'd0);
            chk(out_data == last_out, "R6 head beat data", out_data, last_out);
            repeat (gap) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b1; in_tail = split; in_data = split ? d2 : d1;
        @(negedge clk);
        in_valid = 1'b0; in_tail = 1'b0;
        chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
        chk(out_data == exp, {tag, " data"}, out_data, exp);
        if (!sext && len < 8)
            chk((out_data >> (len * 8)) == 0, "R5 upper zero", out_data, exp);
        chk(out_cr == ecr, rc ? "R8 cond" : "R9 cond off", 64'(out_cr), 64'(ecr));
        last_out = exp;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", 64'(out_valid), 0);
        chk(out_data == 0, "R1 data", out_data, 0);
        chk(out_cr == 0, "R1 cond", 64'(out_cr), 0);
        rst_n = 1'b1;
        last_out = '0;
    endtask

    task automatic t_sweep();
        int    seed;
        string tag;
        seed = 1;
        for (int o = 0; o < 8; o++)
            for (int s = 0; s < 4; s++)
                for (int r = 0; r < 2; r++)
                    for (int x = 0; x < 2; x++) begin
                        bit sp;
                        sp = (o + (1 << s)) > 8;
                        tag = (sp && r != 0) ? "R7" : sp ? "R6" : (r != 0) ? "R3" :
                              (x != 0) ? "R4" : "R2";
                        fill_mem(seed);
                        seed++;
                        access(o, s, r[0], x[0], 1'b0, 0, tag);
                    end
    endtask

    task automatic t_gap();
        fill_mem(77);
        access(5, 2, 1'b0, 1'b1, 1'b0, 3, "R10");
        fill_mem(91);
        access(3, 3, 1'b1, 1'b0, 1'b0, 5, "R10");
    endtask

    task automatic t_record();
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        access(0, 3, 1'b0, 1'b0, 1'b1, 0, "R8 zero");
        mem[2] = 8'h80;
        access(2, 0, 1'b0, 1'b1, 1'b1, 0, "R8 negative");
        mem[2] = 8'h7F;
        access(2, 0, 1'b0, 1'b1, 1'b1, 0, "R8 positive");
        mem[2] = 8'h80;
        access(2, 0, 1'b0, 1'b1, 1'b0, 0, "R9");
        fill_mem(5);
        mem[9] = 8'hC0;
        access(6, 2, 1'b0, 1'b1, 1'b1, 1, "R8 split");
    endtask

    task automatic t_hold();
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R11 idle valid", 64'(out_valid), 0);
            chk(out_data == last_out, "R11 idle data", out_data, last_out);
        end
    endtask

    initial begin
        in_valid = 1'b0; in_tail = 1'b0; in_data = '0; in_offset = '0;
        in_size = '0; in_rev = 1'b0; in_sext = 1'b0; in_rc = 1'b0;
        rst_n = 1'b0;
        t_reset();
        t_sweep();
        t_hold();
        t_gap();
        t_record();
        t_hold();
        finish_run();
    end

endmodule